// File: doc/BRIEF.md
# Three-Wire Serial Control Port

This block is the slave side of a control port for a transceiver. A host modem reaches it over three shared pins and a mode-select strap. With the strap high, the pins carry a strobe, a bidirectional data line and a serial clock. The host writes or reads a small bank of 5-bit registers using fixed 9-bit frames. With the strap low, the same pins are three active-low parallel controls for idle, FM and sleep. The controls pass straight through, and the serial machinery stays quiet.

Each frame opens when the strobe falls and closes when the strobe rises again. Bits are sampled on falling edges of the serial clock, most significant bit first. The frame carries a read/write flag, a 3-bit register address and a 5-bit data field. A write is committed only when the strobe rises after exactly nine clocks. On a read, the port drives the addressed register's bits during the data positions and then releases the line, where an external pull-up holds it high. One register bit acts as a power-down for the reference clock generator and turns its enable output off.

The strobe, clock and data pins are brought into the system clock domain through two-flop synchronizers. Edge detection happens in that domain. Every state element has a defined value after the system reset, so no external timing components are needed.

Top module: `tw_ctrl_port`

## Requirements
- R1: After reset, every register in the bank reads 0, `refclk_en_o` is 1, `data_oe` is 0, and in serial mode `idle_o`, `fm_o` and `sleep_o` are 0.
- R2: While the strobe is high, activity on the serial clock and data pins changes no register and never enables the data driver.
- R3: A frame is sampled on falling serial-clock edges, most significant bit first. Bit 8 is the read flag (1 = read), bits 7:5 are the address and bits 4:0 are the data. A write frame with exactly 9 clocks stores its data field in the addressed register when the strobe rises.
- R4: A write frame with any clock count other than 9 leaves all registers unchanged.
- R5: In a read frame, `data_oe` is 1 from the 4th falling edge until the 9th. During that time `data_o` presents the addressed register's bits 4 down to 0, one bit per clock, so each bit is valid before the falling edge of clocks 5 through 9. At all other times `data_oe` is 0.
- R6: A read frame changes no register, whatever data the host places on the line.
- R7: A strobe fall is accepted only if the strobe was seen high for at least MIN_GAP+1 (default 5) system clocks. A frame whose preceding high time is shorter is ignored entirely.
- R8: With `mode_sel` low, `idle_o`, `fm_o` and `sleep_o` are the inverses of the strobe, data and clock pins respectively. `data_oe` stays 0 and no register is written.
- R9: With `mode_sel` high, `idle_o`, `fm_o` and `sleep_o` follow bits 0, 1 and 2 of register 0.
- R10: Bit 4 of register 7 is the power-down bit. While it is 1, `refclk_en_o` is 0, and clearing it restores `refclk_en_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| mode_sel | input | 1 | 1 = serial control, 0 = parallel control |
| pin_stb_idle_n | input | 1 | Strobe in serial mode, idle control (active low) in parallel mode |
| pin_dat_fm_n | input | 1 | Data input in serial mode, FM control (active low) in parallel mode |
| pin_clk_sleep_n | input | 1 | Serial clock in serial mode, sleep control (active low) in parallel mode |
| data_o | output | 1 | Read data driven onto the data line |
| data_oe | output | 1 | Output enable for the data line driver |
| idle_o | output | 1 | Idle control, active high |
| fm_o | output | 1 | FM control, active high |
| sleep_o | output | 1 | Sleep control, active high |
| refclk_en_o | output | 1 | Reference clock generator enable |
| bank_o | output | 40 | Register bank contents, register k in bits k*5+4:k*5 |

## Verification
A change on a serial pin reaches the edge detectors after two synchronizer stages. It then acts one system clock later, so register writes, read-bit updates and driver release all appear three system clocks after the pin edge that causes them. The bench holds each serial clock phase for eight system clocks. It samples read data just before the next falling edge, and it samples the register bank six cycles after the strobe rises, well past that three-cycle point. In parallel mode the outputs are combinational, so they are checked one nanosecond after the pins are driven.

// File: rtl/tw_ctrl_port.sv
`timescale 1ns/1ps
module tw_ctrl_port #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 5,
  parameter int MIN_GAP  = 4,
  parameter int CTL_ADDR = 0,
  parameter int PWR_ADDR = 7,
  parameter int PWR_BIT  = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          mode_sel,
  input  logic                          pin_stb_idle_n,
  input  logic                          pin_dat_fm_n,
  input  logic                          pin_clk_sleep_n,
  output logic                          data_o,
  output logic                          data_oe,
  output logic                          idle_o,
  output logic                          fm_o,
  output logic                          sleep_o,
  output logic                          refclk_en_o,
  output logic [(1<<ADDR_W)*DATA_W-1:0] bank_o
);

  localparam int FRAME_LEN = 1 + ADDR_W + DATA_W;
  localparam int NREG      = 1 << ADDR_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 2);
  localparam int GAP_W     = $clog2(MIN_GAP + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_HDR = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_LEN);

  logic [2:0] stb_sr, sck_sr;
  logic [1:0] dat_sr;
  logic       stb_fall, stb_rise, sck_fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      stb_sr <= '1;
      sck_sr <= '1;
      dat_sr <= '1;
    end else begin
      stb_sr <= {stb_sr[1:0], pin_stb_idle_n};
      sck_sr <= {sck_sr[1:0], pin_clk_sleep_n};
      dat_sr <= {dat_sr[0], pin_dat_fm_n};
    end

  assign stb_fall = !stb_sr[1] &&  stb_sr[2];
  assign stb_rise =  stb_sr[1] && !stb_sr[2];
  assign sck_fall = !sck_sr[1] &&  sck_sr[2];

  logic [GAP_W-1:0] gap_cnt;
  logic             gap_ok;

  assign gap_ok = (gap_cnt == GAP_W'(MIN_GAP));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)             gap_cnt <= '0;
    else if (!stb_sr[2])    gap_cnt <= '0;
    else if (!gap_ok)       gap_cnt <= gap_cnt + 1'b1;

  logic                 act;
  logic [CNT_W-1:0]     cnt;
  logic [FRAME_LEN-1:0] sh;
  logic [ADDR_W:0]      hdr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act <= 1'b0;
      cnt <= '0;
      sh  <= '0;
      hdr <= '0;
    end else if (!mode_sel) begin
      act <= 1'b0;
      cnt <= '0;
    end else if (stb_fall) begin
      act <= gap_ok;
      cnt <= '0;
    end else if (stb_rise) begin
      act <= 1'b0;
    end else if (act && sck_fall) begin
      sh <= {sh[FRAME_LEN-2:0], dat_sr[1]};
      if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      if (cnt == CNT_HDR) hdr <= {sh[ADDR_W-1:0], dat_sr[1]};
    end

  logic [DATA_W-1:0] bank [NREG];
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;

  assign wr_en   = mode_sel && act && stb_rise && (cnt == CNT_END) && !sh[FRAME_LEN-1];
  assign wr_addr = sh[FRAME_LEN-2 -: ADDR_W];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) bank[k] <= '0;
    end else if (wr_en) begin
      bank[wr_addr] <= sh[DATA_W-1:0];
    end

  for (genvar g = 0; g < NREG; g++) begin : g_bank_out
    assign bank_o[g*DATA_W +: DATA_W] = bank[g];
  end

  logic              rd_phase;
  logic [DATA_W-1:0] rd_word;
  logic              rd_bit;

  assign rd_phase = mode_sel && act && hdr[ADDR_W] && (cnt > CNT_HDR) && (cnt < CNT_END);
  assign rd_word  = bank[hdr[ADDR_W-1:0]];

  always_comb begin
    rd_bit = 1'b1;
    for (int i = 0; i < DATA_W; i++)
      if (cnt == CNT_W'(FRAME_LEN - 1 - i)) rd_bit = rd_word[i];
  end

  assign data_oe = rd_phase;
  assign data_o  = rd_phase ? rd_bit : 1'b1;

  assign idle_o      = mode_sel ? bank[CTL_ADDR][0] : !pin_stb_idle_n;
  assign fm_o        = mode_sel ? bank[CTL_ADDR][1] : !pin_dat_fm_n;
  assign sleep_o     = mode_sel ? bank[CTL_ADDR][2] : !pin_clk_sleep_n;
  assign refclk_en_o = !bank[PWR_ADDR][PWR_BIT];

  AST_IDLE_STROBE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_rise |=> $stable(bank_o)); // R2
  AST_RELEASE_AFTER_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= CNT_END) |-> !data_oe); // R5
  AST_PARALLEL_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_sel |-> !data_oe); // R8
  AST_GAP_BEFORE_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act) |-> $past(gap_ok)); // R7
  AST_SHORT_FRAME_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_rise && act && cnt != CNT_END) |=> $stable(bank_o)); // R4

endmodule

// File: tb/tw_ctrl_port_tb.sv
`timescale 1ns/1ps
module tw_ctrl_port_tb;

  localparam int HP = 8;
  localparam int NV = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_sel = 1'b1;
  logic stb = 1'b1, dat = 1'b1, sck = 1'b1;
  logic data_o, data_oe, idle_o, fm_o, sleep_o, refclk_en_o;
  logic [39:0] bank_o;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [4:0] mdl [8];

  always #2.5 clk = ~clk;

  tw_ctrl_port u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .pin_stb_idle_n(stb), .pin_dat_fm_n(dat), .pin_clk_sleep_n(sck),
    .data_o(data_o), .data_oe(data_oe), .idle_o(idle_o), .fm_o(fm_o),
    .sleep_o(sleep_o), .refclk_en_o(refclk_en_o), .bank_o(bank_o)
  );

  // {read, addr[2:0], data[4:0], clocks[3:0]}
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 3'd1, 5'h15, 4'd9},
    {1'b0, 3'd2, 5'h0A, 4'd9},
    {1'b0, 3'd5, 5'h1F, 4'd9},
    {1'b1, 3'd1, 5'h00, 4'd9},
    {1'b0, 3'd1, 5'h03, 4'd8},
    {1'b0, 3'd1, 5'h07, 4'd10},
    {1'b1, 3'd1, 5'h1F, 4'd9},
    {1'b1, 3'd2, 5'h15, 4'd9},
    {1'b0, 3'd3, 5'h11, 4'd9},
    {1'b1, 3'd5, 5'h0C, 4'd9},
    {1'b1, 3'd3, 5'h00, 4'd9},
    {1'b0, 3'd0, 5'h05, 4'd9},
    {1'b0, 3'd7, 5'h10, 4'd9},
    {1'b0, 3'd7, 5'h00, 4'd9}
  };

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
    end
  endtask

  task automatic chk_bank(input string req);
    for (int k = 0; k < 8; k++)
      chk(bank_o[k*5 +: 5] === mdl[k], req, int'(bank_o[k*5 +: 5]), int'(mdl[k]));
  endtask

  task automatic frame(input logic rd, input logic [2:0] a, input logic [4:0] d,
                       input int nclk, input int gap, input logic [4:0] exp_rd,
                       input bit chk_rd);
    logic [8:0] word;
    word = {rd, a, d};
    repeat (gap) @(negedge clk);
    stb = 1'b0;
    repeat (HP) @(negedge clk);
    for (int i = 0; i < nclk; i++) begin
      dat = (i < 9) ? word[8-i] : 1'b0;
      repeat (HP) @(negedge clk);
      if (chk_rd) begin
        if (i >= 4 && i < 9)
          chk(data_oe === 1'b1 && data_o === exp_rd[8-i], "R5 read bit",
              int'({data_oe, data_o}), int'({1'b1, exp_rd[8-i]}));
        else
          chk(data_oe === 1'b0, "R5 driver off in header", int'(data_oe), 0);
      end
      sck = 1'b0;
      repeat (HP) @(negedge clk);
      sck = 1'b1;
    end
    repeat (HP) @(negedge clk);
    if (chk_rd) chk(data_oe === 1'b0, "R5 release after 9th clock", int'(data_oe), 0);
    stb = 1'b1;
    dat = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) mdl[k] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state
    chk_bank("R1 bank reset");
    chk(refclk_en_o === 1'b1, "R1 refclk enable", int'(refclk_en_o), 1);
    chk(data_oe === 1'b0, "R1 driver off", int'(data_oe), 0);
    chk({idle_o, fm_o, sleep_o} === 3'b000, "R1 controls", int'({idle_o, fm_o, sleep_o}), 0);

    // Vector table: R3 writes, R4 wrong counts, R5/R6 reads, R9/R10 side outputs
    for (int v = 0; v < NV; v++) begin
      logic       rd;
      logic [2:0] a;
      logic [4:0] d;
      int         n;
      rd = VEC[v][12];
      a  = VEC[v][11:9];
      d  = VEC[v][8:4];
      n  = int'(VEC[v][3:0]);
      frame(rd, a, d, n, 12, mdl[a], rd && n == 9);
      repeat (6) @(negedge clk);
      if (!rd && n == 9) mdl[a] = d;
      chk_bank(rd ? "R6 read leaves bank" : (n == 9 ? "R3 write" : "R4 bad count"));
      chk({sleep_o, fm_o, idle_o} === mdl[0][2:0], "R9 serial controls",
          int'({sleep_o, fm_o, idle_o}), int'(mdl[0][2:0]));
      chk(refclk_en_o === !mdl[7][4], "R10 power-down", int'(refclk_en_o), int'(!mdl[7][4]));
    end

    // R2: clock and data activity with strobe high
    for (int t = 0; t < 20; t++) begin
      sck = ~sck;
      dat = t[1];
      repeat (4) @(negedge clk);
      chk(data_oe === 1'b0, "R2 no drive with strobe high", int'(data_oe), 0);
    end
    sck = 1'b1;
    dat = 1'b1;
    repeat (8) @(negedge clk);
    chk_bank("R2 strobe-high activity");

    // R7: too short a strobe-high gap
    frame(1'b0, 3'd4, 5'h0E, 9, 12, 5'h00, 1'b0);
    frame(1'b0, 3'd4, 5'h1F, 9, 1, 5'h00, 1'b0);
    repeat (6) @(negedge clk);
    mdl[4] = 5'h0E;
    chk(bank_o[20 +: 5] === 5'h0E, "R7 short gap frame ignored", int'(bank_o[20 +: 5]), 'h0E);
    frame(1'b1, 3'd4, 5'h00, 9, 12, 5'h0E, 1'b1);

    // R8: parallel mode decoding
    repeat (6) @(negedge clk);
    mode_sel = 1'b0;
    for (int p = 0; p < 8; p++) begin
      {stb, dat, sck} = 3'(p);
      #1;
      chk({idle_o, fm_o, sleep_o} === ~3'(p), "R8 parallel decode",
          int'({idle_o, fm_o, sleep_o}), int'(~3'(p)));
      chk(data_oe === 1'b0, "R8 parallel no drive", int'(data_oe), 0);
      @(negedge clk);
    end
    {stb, dat, sck} = 3'b111;
    repeat (4) @(negedge clk);
    frame(1'b0, 3'd6, 5'h1B, 9, 12, 5'h00, 1'b0);
    repeat (6) @(negedge clk);
    mode_sel = 1'b1;
    repeat (12) @(negedge clk);
    chk_bank("R8 no write in parallel mode");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired before all requirements were checked");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule